// File: doc/BRIEF.md
# SPI FIFO Status and Interrupt Unit

This unit sits between the register bus and the shift engine of an SPI controller. It holds two byte queues. The transmit queue is filled by the bus and drained by the shift engine. The receive queue is filled by the shift engine and drained by the bus. Software reads both fill counts from a single status word. Each direction has an 8-bit threshold, and that threshold drives both a level interrupt flag and a DMA request line.

Four event flags sit in a status word that software clears by writing ones: receive-ready, transmit-low, receive-overflow and transfer-done. An enable word masks those flags into a single interrupt line. A one-shot bit for each queue in the control word empties that queue, and the bit then clears itself. Queue depth is a parameter, normally 64 or 128 bytes.

Top module: `spi_buf_evt`

## Requirements
- R1: While reset is held, the control, enable, event status and fill-count words all read zero, and `irq`, `rx_dreq` and `tx_dreq` are low.
- R2: Each queue returns bytes in the order they were accepted, and the oldest byte is always visible on its head output while the queue is not empty.
- R3: The fill-count word carries the receive count in bits 7:0 and the transmit count in bits 23:16. A count changes on the edge that accepts a push or a pop. An accepted push and an accepted pop on the same edge leave the count unchanged.
- R4: A push into a full queue is dropped, even when a pop happens on the same edge. A receive push at full also sets the overflow flag, status bit 8. A pop from an empty queue has no effect.
- R5: Writing 1 to control bit 15 (receive) or bit 31 (transmit) makes that bit read 1 for exactly one cycle. On the next edge the queue empties and the bit reads 0 again. Pushes are refused during that flush cycle. The other control fields keep their written values.
- R6: Control bits 7:0 set the receive threshold and bits 23:16 set the transmit threshold. Status bit 0 is set on the edge after the receive count is at or above its threshold. Status bit 4 is set on the edge after the transmit count is at or below its threshold. Both flags stay set until software clears them.
- R7: A status write clears every flag whose data bit is 1. For bits 0 and 4 the clear takes priority for one cycle, so a flag whose condition still holds reads 0 for one cycle and then returns. For bits 8 and 12 a new event on the same edge takes priority over the clear.
- R8: A pulse on `xfer_done` sets status bit 12.
- R9: The enable word keeps only bits 0, 4, 8 and 12, and all other bits read zero. `irq` is high exactly when some status bit and its matching enable bit are both 1.
- R10: `rx_dreq` is high while control bit 8 is 1 and the receive count is at or above its threshold. `tx_dreq` is high while control bit 24 is 1 and the transmit count is at or below its threshold. Neither depends on the status flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Write strobe for the control word |
| ctl_wdata | input | 32 | Control word write data |
| ctl_rdata | output | 32 | Control word readback |
| ien_we | input | 1 | Write strobe for the interrupt enable word |
| ien_wdata | input | 32 | Enable word write data |
| ien_rdata | output | 32 | Enable word readback |
| sts_w1c | input | 1 | Write strobe for the event status word (ones clear) |
| sts_wdata | input | 32 | Clear mask |
| sts_rdata | output | 32 | Event status word |
| fsts_rdata | output | 32 | Fill-count word |
| txq_push | input | 1 | Bus pushes a byte into the transmit queue |
| txq_wbyte | input | 8 | Byte for the transmit queue |
| txq_pop | input | 1 | Shift engine takes the transmit head |
| txq_head | output | 8 | Oldest transmit byte |
| rxq_push | input | 1 | Shift engine pushes a received byte |
| rxq_wbyte | input | 8 | Received byte |
| rxq_pop | input | 1 | Bus takes the receive head |
| rxq_head | output | 8 | Oldest receive byte |
| xfer_done | input | 1 | Transfer-complete pulse from the shift engine |
| tx_dreq | output | 1 | Transmit DMA request |
| rx_dreq | output | 1 | Receive DMA request |
| irq | output | 1 | Masked interrupt |

## Verification
The bench builds the unit with a depth of 64. At that depth a full queue is reached in a few dozen cycles, so overflow, push-plus-pop at full, and flush of a full queue can all be driven directly. The 8-bit thresholds can also be set above the depth at that size, which covers a receive request that can never fire and a transmit request that always does. A random phase moves the thresholds, the flushes, the clear masks and the enables while both queues swing between empty and full.

// File: rtl/spi_buf_pkg.sv
package spi_buf_pkg;

  // Event flag slots inside the status and enable words. Software decodes
  // these positions, so they are fixed.
  localparam int unsigned EV_RRDY  = 0;
  localparam int unsigned EV_TLOW  = 1;
  localparam int unsigned EV_ROVF  = 2;
  localparam int unsigned EV_XDONE = 3;
  localparam int unsigned NEV      = 4;

  // Only the two threshold flags re-arm from their condition.
  localparam logic [NEV-1:0] LEVEL_EVENTS = 4'b0011;

  typedef struct packed {
    logic       tclr;
    logic       tdma;
    logic [7:0] ttrig;
    logic       rclr;
    logic       rdma;
    logic [7:0] rtrig;
  } ctl_t;

  function automatic ctl_t ctl_unpack(logic [31:0] w);
    ctl_t c;
    c.rtrig = w[7:0];
    c.rdma  = w[8];
    c.rclr  = w[15];
    c.ttrig = w[23:16];
    c.tdma  = w[24];
    c.tclr  = w[31];
    return c;
  endfunction

  function automatic logic [31:0] ctl_pack(ctl_t c);
    logic [31:0] w;
    w        = '0;
    w[7:0]   = c.rtrig;
    w[8]     = c.rdma;
    w[15]    = c.rclr;
    w[23:16] = c.ttrig;
    w[24]    = c.tdma;
    w[31]    = c.tclr;
    return w;
  endfunction

  // Event slot i lives at word bit 4*i.
  function automatic logic [NEV-1:0] ev_gather(logic [31:0] w);
    return {w[12], w[8], w[4], w[0]};
  endfunction

  function automatic logic [31:0] ev_spread(logic [NEV-1:0] e);
    logic [31:0] w;
    w     = '0;
    w[0]  = e[0];
    w[4]  = e[1];
    w[8]  = e[2];
    w[12] = e[3];
    return w;
  endfunction

  function automatic logic fill_at_least(logic [8:0] cnt, logic [7:0] lvl);
    return cnt >= {1'b0, lvl};
  endfunction

  function automatic logic fill_at_most(logic [8:0] cnt, logic [7:0] lvl);
    return cnt <= {1'b0, lvl};
  endfunction

endpackage

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [7:0]    din,
  input  logic          pop,
  output logic [7:0]    head,
  output logic [CW-1:0] level,
  output logic          full,
  output logic          push_ok,
  output logic          pop_ok
);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full    = (level == CW'(DEPTH));
  assign push_ok = push && !full && !flush;
  assign pop_ok  = pop && (level != '0) && !flush;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push_ok) wr_ptr <= bump(wr_ptr);
      if (pop_ok)  rd_ptr <= bump(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   level <= level + CW'(1);
        2'b01:   level <= level - CW'(1);
        default: level <= level;
      endcase
    end
  end

endmodule

// File: rtl/spi_evt_status.sv
module spi_evt_status #(
  parameter int unsigned    NB         = 4,
  parameter logic [NB-1:0]  LEVEL_MASK = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] cause,
  input  logic [NB-1:0] wipe,
  output logic [NB-1:0] flags
);

  for (genvar i = 0; i < NB; i++) begin : g_bit
    logic q;
    if (LEVEL_MASK[i]) begin : g_level
      // Clear wins for a cycle; the still-true condition re-arms next edge.
      always_ff @(posedge clk) begin
        if (!rst_n)        q <= 1'b0;
        else if (wipe[i])  q <= 1'b0;
        else if (cause[i]) q <= 1'b1;
      end
    end else begin : g_sticky
      // A fresh event is never lost to a coincident clear.
      always_ff @(posedge clk) begin
        if (!rst_n)        q <= 1'b0;
        else if (cause[i]) q <= 1'b1;
        else if (wipe[i])  q <= 1'b0;
      end
    end
    assign flags[i] = q;
  end

endmodule

// File: rtl/spi_cfg_bank.sv
module spi_cfg_bank
  import spi_buf_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ctl_we,
  input  logic [31:0]    ctl_wdata,
  input  logic           ien_we,
  input  logic [31:0]    ien_wdata,
  output ctl_t           ctl,
  output logic [NEV-1:0] ien
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl <= '0;
    end else if (ctl_we) begin
      ctl <= ctl_unpack(ctl_wdata);
    end else begin
      ctl.rclr <= 1'b0;
      ctl.tclr <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      ien <= '0;
    else if (ien_we) ien <= ev_gather(ien_wdata);
  end

endmodule

// File: rtl/spi_buf_evt.sv
module spi_buf_evt
  import spi_buf_pkg::*;
#(
  parameter int unsigned DEPTH = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctl_we,
  input  logic [31:0] ctl_wdata,
  output logic [31:0] ctl_rdata,
  input  logic        ien_we,
  input  logic [31:0] ien_wdata,
  output logic [31:0] ien_rdata,
  input  logic        sts_w1c,
  input  logic [31:0] sts_wdata,
  output logic [31:0] sts_rdata,
  output logic [31:0] fsts_rdata,
  input  logic        txq_push,
  input  logic [7:0]  txq_wbyte,
  input  logic        txq_pop,
  output logic [7:0]  txq_head,
  input  logic        rxq_push,
  input  logic [7:0]  rxq_wbyte,
  input  logic        rxq_pop,
  output logic [7:0]  rxq_head,
  input  logic        xfer_done,
  output logic        tx_dreq,
  output logic        rx_dreq,
  output logic        irq
);

  // DEPTH must stay within 2..255 so a count fits its 8-bit field.
  localparam int unsigned CW = $clog2(DEPTH + 1);

  ctl_t           ctl;
  logic [NEV-1:0] ien;
  logic [NEV-1:0] ev_cause, ev_wipe, ev_flags;

  logic [CW-1:0]  rx_cnt, tx_cnt;
  logic           rx_full, tx_full;
  logic           rx_push_ok, rx_pop_ok, tx_push_ok, tx_pop_ok;
  logic           rx_hit, tx_hit, rx_ovf_evt;

  spi_cfg_bank u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_we    (ctl_we),
    .ctl_wdata (ctl_wdata),
    .ien_we    (ien_we),
    .ien_wdata (ien_wdata),
    .ctl       (ctl),
    .ien       (ien)
  );

  spi_byte_fifo #(.DEPTH(DEPTH)) u_txq (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (ctl.tclr),
    .push    (txq_push),
    .din     (txq_wbyte),
    .pop     (txq_pop),
    .head    (txq_head),
    .level   (tx_cnt),
    .full    (tx_full),
    .push_ok (tx_push_ok),
    .pop_ok  (tx_pop_ok)
  );

  spi_byte_fifo #(.DEPTH(DEPTH)) u_rxq (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (ctl.rclr),
    .push    (rxq_push),
    .din     (rxq_wbyte),
    .pop     (rxq_pop),
    .head    (rxq_head),
    .level   (rx_cnt),
    .full    (rx_full),
    .push_ok (rx_push_ok),
    .pop_ok  (rx_pop_ok)
  );

  assign rx_hit     = fill_at_least(9'(rx_cnt), ctl.rtrig);
  assign tx_hit     = fill_at_most(9'(tx_cnt), ctl.ttrig);
  assign rx_ovf_evt = rxq_push && rx_full && !ctl.rclr;

  always_comb begin
    ev_cause           = '0;
    ev_cause[EV_RRDY]  = rx_hit;
    ev_cause[EV_TLOW]  = tx_hit;
    ev_cause[EV_ROVF]  = rx_ovf_evt;
    ev_cause[EV_XDONE] = xfer_done;
  end

  assign ev_wipe = sts_w1c ? ev_gather(sts_wdata) : '0;

  spi_evt_status #(.NB(NEV), .LEVEL_MASK(LEVEL_EVENTS)) u_evt (
    .clk   (clk),
    .rst_n (rst_n),
    .cause (ev_cause),
    .wipe  (ev_wipe),
    .flags (ev_flags)
  );

  assign ctl_rdata  = ctl_pack(ctl);
  assign ien_rdata  = ev_spread(ien);
  assign sts_rdata  = ev_spread(ev_flags);
  assign fsts_rdata = {8'h00, 8'(tx_cnt), 8'h00, 8'(rx_cnt)};
  assign irq        = |(ev_flags & ien);
  assign rx_dreq    = ctl.rdma && rx_hit;
  assign tx_dreq    = ctl.tdma && tx_hit;

endmodule

// File: rtl/spi_buf_evt_chk.sv
module spi_buf_evt_chk #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ctl_we,
  input logic [31:0]   ctl_wdata,
  input logic [31:0]   ctl_rdata,
  input logic [31:0]   ien_rdata,
  input logic          sts_w1c,
  input logic [31:0]   sts_wdata,
  input logic [31:0]   sts_rdata,
  input logic          xfer_done,
  input logic          irq,
  input logic          rx_dreq,
  input logic          tx_dreq,
  input logic          rxq_push,
  input logic          rxq_pop,
  input logic          txq_push,
  input logic          txq_pop,
  input logic [CW-1:0] rx_cnt,
  input logic [CW-1:0] tx_cnt,
  input logic          rx_full,
  input logic          tx_full,
  input logic          rx_push_ok,
  input logic          rx_pop_ok,
  input logic          tx_push_ok,
  input logic          tx_pop_ok,
  input logic          rx_hit,
  input logic          rx_ovf_evt
);

  a_r3_rx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= CW'(DEPTH));

  a_r3_rx_balance: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push_ok && rx_pop_ok |=> $stable(rx_cnt));

  a_r3_tx_balance: assert property (@(posedge clk) disable iff (!rst_n)
    tx_push_ok && tx_pop_ok |=> $stable(tx_cnt));

  a_r4_rx_drop: assert property (@(posedge clk) disable iff (!rst_n)
    rxq_push && rx_full && !rxq_pop && !ctl_rdata[15] |=> $stable(rx_cnt));

  a_r4_tx_drop: assert property (@(posedge clk) disable iff (!rst_n)
    txq_push && tx_full && !txq_pop && !ctl_rdata[31] |=> $stable(tx_cnt));

  a_r4_ovf_flag: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ovf_evt |=> sts_rdata[8]);

  a_r5_rx_flush: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdata[15] |=> rx_cnt == '0);

  a_r5_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdata[15] && !(ctl_we && ctl_wdata[15]) |=> !ctl_rdata[15]);

  a_r6_rx_ready: assert property (@(posedge clk) disable iff (!rst_n)
    rx_hit && !(sts_w1c && sts_wdata[0]) |=> sts_rdata[0]);

  a_r7_level_wipe: assert property (@(posedge clk) disable iff (!rst_n)
    sts_w1c && sts_wdata[0] |=> !sts_rdata[0]);

  a_r8_done_flag: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> sts_rdata[12]);

  a_r9_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ien_rdata == '0 |-> !irq);

  a_r10_rx_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_rdata[8] |-> !rx_dreq);

  a_r10_tx_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_rdata[24] |-> !tx_dreq);

endmodule

bind spi_buf_evt spi_buf_evt_chk #(.DEPTH(DEPTH)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .ctl_we     (ctl_we),
  .ctl_wdata  (ctl_wdata),
  .ctl_rdata  (ctl_rdata),
  .ien_rdata  (ien_rdata),
  .sts_w1c    (sts_w1c),
  .sts_wdata  (sts_wdata),
  .sts_rdata  (sts_rdata),
  .xfer_done  (xfer_done),
  .irq        (irq),
  .rx_dreq    (rx_dreq),
  .tx_dreq    (tx_dreq),
  .rxq_push   (rxq_push),
  .rxq_pop    (rxq_pop),
  .txq_push   (txq_push),
  .txq_pop    (txq_pop),
  .rx_cnt     (rx_cnt),
  .tx_cnt     (tx_cnt),
  .rx_full    (rx_full),
  .tx_full    (tx_full),
  .rx_push_ok (rx_push_ok),
  .rx_pop_ok  (rx_pop_ok),
  .tx_push_ok (tx_push_ok),
  .tx_pop_ok  (tx_pop_ok),
  .rx_hit     (rx_hit),
  .rx_ovf_evt (rx_ovf_evt)
);

// File: tb/spi_buf_evt_tb_top.sv
`timescale 1ns/1ps
module spi_buf_evt_tb_top;

  localparam int unsigned DEPTH = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_we, ien_we, sts_w1c, xfer_done;
  logic [31:0] ctl_wdata, ien_wdata, sts_wdata;
  logic [31:0] ctl_rdata, ien_rdata, sts_rdata, fsts_rdata;
  logic        txq_push, txq_pop, rxq_push, rxq_pop;
  logic [7:0]  txq_wbyte, rxq_wbyte, txq_head, rxq_head;
  logic        tx_dreq, rx_dreq, irq;

  int nchecks = 0;
  int nerrs   = 0;
  bit cmp_on  = 1'b0;

  always #4 clk = ~clk;

  spi_buf_evt #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .ien_we(ien_we), .ien_wdata(ien_wdata), .ien_rdata(ien_rdata),
    .sts_w1c(sts_w1c), .sts_wdata(sts_wdata), .sts_rdata(sts_rdata),
    .fsts_rdata(fsts_rdata),
    .txq_push(txq_push), .txq_wbyte(txq_wbyte), .txq_pop(txq_pop), .txq_head(txq_head),
    .rxq_push(rxq_push), .rxq_wbyte(rxq_wbyte), .rxq_pop(rxq_pop), .rxq_head(rxq_head),
    .xfer_done(xfer_done), .tx_dreq(tx_dreq), .rx_dreq(rx_dreq), .irq(irq)
  );

  // ---------------- behavioural reference ----------------
  logic [7:0] m_rxq[$];
  logic [7:0] m_txq[$];
  logic [7:0] m_rtrig, m_ttrig;
  bit         m_rdma, m_tdma, m_rclr, m_tclr;
  bit         m_en[4];
  bit         m_st[4];

  always @(posedge clk) begin : model
    int rs, ts;
    bit rhit, thit, ovf;
    bit wipe[4];
    if (!rst_n) begin
      m_rxq.delete(); m_txq.delete();
      m_rtrig = 0; m_ttrig = 0;
      m_rdma = 0; m_tdma = 0; m_rclr = 0; m_tclr = 0;
      for (int k = 0; k < 4; k++) begin m_en[k] = 0; m_st[k] = 0; end
    end else begin
      rs = m_rxq.size(); ts = m_txq.size();
      rhit = (rs >= int'(m_rtrig));
      thit = (ts <= int'(m_ttrig));
      ovf = 0;
      if (m_rclr) m_rxq.delete();
      else begin
        if (rxq_pop && rs > 0) void'(m_rxq.pop_front());
        if (rxq_push) begin
          if (rs < DEPTH) m_rxq.push_back(rxq_wbyte); else ovf = 1;
        end
      end
      if (m_tclr) m_txq.delete();
      else begin
        if (txq_pop && ts > 0) void'(m_txq.pop_front());
        if (txq_push && ts < DEPTH) m_txq.push_back(txq_wbyte);
      end
      for (int k = 0; k < 4; k++) wipe[k] = sts_w1c && sts_wdata[4*k];
      if (wipe[0]) m_st[0] = 0; else if (rhit) m_st[0] = 1;
      if (wipe[1]) m_st[1] = 0; else if (thit) m_st[1] = 1;
      if (ovf) m_st[2] = 1; else if (wipe[2]) m_st[2] = 0;
      if (xfer_done) m_st[3] = 1; else if (wipe[3]) m_st[3] = 0;
      if (ctl_we) begin
        m_rtrig = ctl_wdata[7:0];   m_rdma = ctl_wdata[8];  m_rclr = ctl_wdata[15];
        m_ttrig = ctl_wdata[23:16]; m_tdma = ctl_wdata[24]; m_tclr = ctl_wdata[31];
      end else begin
        m_rclr = 0; m_tclr = 0;
      end
      if (ien_we) for (int k = 0; k < 4; k++) m_en[k] = ien_wdata[4*k];
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchecks++;
    if (act !== exp) begin
      nerrs++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] spread4(bit b[4]);
    logic [31:0] w = '0;
    for (int k = 0; k < 4; k++) w[4*k] = b[k];
    return w;
  endfunction

  // Compare every cycle, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && cmp_on) begin : cmp
      logic [31:0] ectl;
      bit eirq;
      ectl = {m_tclr, 6'b0, m_tdma, m_ttrig, m_rclr, 6'b0, m_rdma, m_rtrig};
      chk("R5/R6 control word", ctl_rdata, ectl);
      chk("R9 enable word", ien_rdata, spread4(m_en));
      chk("R6/R7/R8 status word", sts_rdata, spread4(m_st));
      chk("R3 fill counts", fsts_rdata,
          {8'h00, 8'(m_txq.size()), 8'h00, 8'(m_rxq.size())});
      eirq = 0;
      for (int k = 0; k < 4; k++) eirq |= m_st[k] & m_en[k];
      chk("R9 irq", 32'(irq), 32'(eirq));
      chk("R10 rx_dreq", 32'(rx_dreq),
          32'(m_rdma && (m_rxq.size() >= int'(m_rtrig))));
      chk("R10 tx_dreq", 32'(tx_dreq),
          32'(m_tdma && (m_txq.size() <= int'(m_ttrig))));
      if (m_rxq.size() > 0) chk("R2 rx head", 32'(rxq_head), 32'(m_rxq[0]));
      if (m_txq.size() > 0) chk("R2 tx head", 32'(txq_head), 32'(m_txq[0]));
    end
  end

  // ---------------- stimulus ----------------
  task automatic quiet();
    ctl_we = 0; ien_we = 0; sts_w1c = 0; xfer_done = 0;
    txq_push = 0; txq_pop = 0; rxq_push = 0; rxq_pop = 0;
    ctl_wdata = '0; ien_wdata = '0; sts_wdata = '0;
    txq_wbyte = '0; rxq_wbyte = '0;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrs);
    $finish;
  endtask

  function automatic logic [31:0] rnd(logic [31:0] s);
    s ^= s << 13; s ^= s >> 17; s ^= s << 5;
    return s;
  endfunction

  initial begin
    repeat (60000) @(posedge clk);
    nerrs++;
    $display("FAIL watchdog: actual hung expected finished run");
    finish_run();
  end

  initial begin
    logic [31:0] lf, ld;
    quiet();
    repeat (4) step();
    // R1: reset values
    chk("R1 control", ctl_rdata, 32'h0);
    chk("R1 enable", ien_rdata, 32'h0);
    chk("R1 status", sts_rdata, 32'h0);
    chk("R1 counts", fsts_rdata, 32'h0);
    chk("R1 outputs", {29'h0, irq, rx_dreq, tx_dreq}, 32'h0);
    rst_n = 1; cmp_on = 1;
    step();
    chk("R6 tx-low after reset", 32'(sts_rdata[4]), 32'h1);

    ien_we = 1; ien_wdata = 32'hFFFF_FFFF; step(); quiet();
    chk("R9 enable keeps 4 bits", ien_rdata, 32'h0000_1111);
    chk("R9 irq from tx-low", 32'(irq), 32'h1);

    ctl_we = 1; ctl_wdata = 32'h0102_0104; step(); quiet();
    chk("R10 tx request at empty", 32'(tx_dreq), 32'h1);
    chk("R10 rx request below level", 32'(rx_dreq), 32'h0);

    for (int i = 0; i < 6; i++) begin
      txq_push = 1; txq_wbyte = 8'hA0 + 8'(i); step();
    end
    quiet();
    chk("R3 tx count six", fsts_rdata, 32'h0006_0000);
    chk("R10 tx request above level", 32'(tx_dreq), 32'h0);
    for (int i = 0; i < 6; i++) begin
      chk("R2 tx order", 32'(txq_head), 32'hA0 + 32'(i));
      txq_pop = 1; step(); quiet();
    end
    txq_pop = 1; step(); quiet();
    chk("R4 pop on empty", fsts_rdata, 32'h0);

    for (int i = 0; i < DEPTH + 3; i++) begin
      rxq_push = 1; rxq_wbyte = 8'(i); step();
    end
    quiet();
    chk("R4 rx full count", fsts_rdata, 32'(DEPTH));
    chk("R4 overflow flag", 32'(sts_rdata[8]), 32'h1);
    chk("R4 head survives overflow", 32'(rxq_head), 32'h0);
    chk("R6 rx ready", 32'(sts_rdata[0]), 32'h1);
    chk("R10 rx request", 32'(rx_dreq), 32'h1);

    rxq_push = 1; rxq_wbyte = 8'hEE; rxq_pop = 1; step(); quiet();
    chk("R4 push+pop at full", fsts_rdata, 32'(DEPTH - 1));
    chk("R2 rx next head", 32'(rxq_head), 32'h1);

    sts_w1c = 1; sts_wdata = 32'h1; step(); quiet();
    chk("R7 level flag cleared", 32'(sts_rdata[0]), 32'h0);
    step();
    chk("R7 level flag re-arms", 32'(sts_rdata[0]), 32'h1);

    sts_w1c = 1; sts_wdata = 32'h100; step(); quiet();
    chk("R7 overflow cleared", 32'(sts_rdata[8]), 32'h0);
    step();
    chk("R7 overflow stays clear", 32'(sts_rdata[8]), 32'h0);

    xfer_done = 1; step(); quiet();
    chk("R8 done flag", 32'(sts_rdata[12]), 32'h1);
    xfer_done = 1; sts_w1c = 1; sts_wdata = 32'h1000; step(); quiet();
    chk("R7 event beats clear", 32'(sts_rdata[12]), 32'h1);
    sts_w1c = 1; sts_wdata = 32'h1000; step(); quiet();
    chk("R7 done cleared", 32'(sts_rdata[12]), 32'h0);

    ctl_we = 1; ctl_wdata = 32'h0102_01C8; step(); quiet();
    chk("R10 level above depth", 32'(rx_dreq), 32'h0);

    ctl_we = 1; ctl_wdata = 32'h0102_8104; step(); quiet();
    chk("R5 flush bit visible", 32'(ctl_rdata[15]), 32'h1);
    chk("R5 count before flush", fsts_rdata, 32'(DEPTH - 1));
    step();
    chk("R5 flush bit self-clears", ctl_rdata, 32'h0102_0104);
    chk("R5 rx emptied", fsts_rdata, 32'h0);

    for (int i = 0; i < 3; i++) begin
      txq_push = 1; txq_wbyte = 8'(i); step();
    end
    ctl_we = 1; ctl_wdata = 32'h8102_0104; txq_push = 0; step(); quiet();
    step();
    chk("R5 tx emptied", fsts_rdata, 32'h0);

    ien_we = 1; ien_wdata = 32'h0; step(); quiet();
    chk("R9 all masked", 32'(irq), 32'h0);

    lf = 32'h1234_5678;
    for (int n = 0; n < 3000; n++) begin
      bit fillmode;
      lf = rnd(lf); ld = rnd(lf ^ 32'h9E37_79B9);
      fillmode = ((n / 400) % 2) == 0;
      rxq_push  = fillmode ? (lf[2:0] != 0) : (lf[2:0] == 0);
      rxq_pop   = fillmode ? (lf[4:3] == 0) : (lf[4:3] != 0);
      txq_push  = fillmode ? (lf[6:5] != 0) : (lf[6:5] == 0);
      txq_pop   = fillmode ? (lf[8:7] == 0) : (lf[8:7] != 0);
      rxq_wbyte = ld[7:0];
      txq_wbyte = ld[15:8];
      xfer_done = (lf[12:9] == 0);
      sts_w1c   = (lf[15:13] == 0);
      sts_wdata = ld;
      ien_we    = (lf[20:16] == 0);
      ien_wdata = rnd(ld);
      ctl_we    = (lf[26:21] == 0);
      ctl_wdata = {ld[16] & ld[17] & ld[18], 6'b0, ld[19], 1'b0, ld[26:20],
                   ld[27] & ld[28] & ld[29], 6'b0, ld[30], 1'b0, lf[31:25]};
      step();
    end
    quiet();
    repeat (3) step();
    finish_run();
  end

endmodule